// File: doc/BRIEF.md
# Perspective-Correct Attribute Interpolator

This block turns per-primitive plane coefficients into per-pixel attribute values for a 2×2 quad of samples every clock. Each attribute U (colour, depth, texture coordinate and so on) arrives as two linear planes: one for U/W and one for 1/W. Each plane is written as A·x + B·y + C. The block evaluates both planes at the four sample positions. It then takes the reciprocal of the 1/W plane to recover W and multiplies U/W by W. The result is the perspective-correct value (A_U·x + B_U·y + C_U) / (A_W·x + B_W·y + C_W).

All values are signed Q16.16. The reciprocal comes from a pipelined shift-subtract divider, one quotient bit per stage, so a new quad is accepted on every cycle. A linear mode sends the U/W plane value straight to the output and ignores the W plane. Latency is fixed and there is no back-pressure. The valid flag travels alongside the data.

Top module: `persp_interp`

## Requirements
- R1: Coefficients, coordinates and results are signed Q16.16 in 32 bits. A plane value at (x, y) is floor(A·x / 2^16) + floor(B·y / 2^16) + C, where each product is a full signed product shifted right arithmetically, and the sum wraps modulo 2^32.
- R2: A group is a quad built from the base coordinate. Lane 0 is (x, y), lane 1 is (x+1.0, y), lane 2 is (x, y+1.0) and lane 3 is (x+1.0, y+1.0). Lane k is returned on attr_o bits [32k+31:32k].
- R3: In perspective mode (linear_i = 0), let P_w be the W-plane value and P_u the U-plane value of a lane. The block forms W = sign(P_w) · floor(2^32 / |P_w|) on raw values. The lane result is the low 32 bits of floor(P_u · W / 2^16).
- R4: When |P_w| is 2 raw units or less (this includes zero), W saturates to +0x7FFFFFFF. If P_w is negative, W saturates to −0x7FFFFFFF instead. Lanes of the same quad that are not in this range are unaffected.
- R5: In linear mode (linear_i = 1), the lane result is P_u. The W coefficients have no effect.
- R6: A group accepted on a rising edge with valid_i high appears with valid_o high after exactly 34 rising edges, counting the accepting edge. A new group may be accepted on every edge, and results leave in acceptance order.
- R7: valid_o is low during reset and after it. It is also low in every cycle that no accepted group reaches the output. Data presented with valid_i low produces nothing.
- R8: Consecutive groups are independent. Mode, coefficients and base coordinate may change on every cycle without affecting the results of neighbouring groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Group present on the inputs this cycle |
| linear_i | input | 1 | 1: linear result, 0: perspective-corrected result |
| base_x_i | input | 32 | Q16.16 x of lane 0 |
| base_y_i | input | 32 | Q16.16 y of lane 0 |
| u_a_i | input | 32 | x coefficient of the U/W plane |
| u_b_i | input | 32 | y coefficient of the U/W plane |
| u_c_i | input | 32 | Constant of the U/W plane |
| w_a_i | input | 32 | x coefficient of the 1/W plane |
| w_b_i | input | 32 | y coefficient of the 1/W plane |
| w_c_i | input | 32 | Constant of the 1/W plane |
| valid_o | output | 1 | Result group present |
| attr_o | output | 128 | Four Q16.16 lane results, lane 0 in the low word |

## Verification
Within one quad, a lane whose 1/W value lands in the saturation band can share the cycle with a lane that takes the ordinary reciprocal path. The bench provokes this with a W plane whose x step is a single raw unit. It sweeps the plane constant through zero, so neighbouring lanes straddle the boundary at ±2 and the sign change. Each lane is compared against an arithmetic model of R3 and R4. In the same stream, linear and perspective groups alternate on adjacent cycles, and each result is checked against its own mode.

// File: rtl/persp_interp_pkg.sv
package persp_interp_pkg;

  localparam int unsigned FRAC_W     = 16;
  localparam int unsigned QUAD_LANES = 4;

  typedef enum logic {
    MODE_PERSP  = 1'b0,
    MODE_LINEAR = 1'b1
  } interp_mode_e;

endpackage

// File: rtl/persp_interp_plane.sv
module persp_interp_plane
  import persp_interp_pkg::*;
#(
  parameter  int unsigned FRAC  = FRAC_W,
  parameter  int unsigned LANES = QUAD_LANES,
  localparam int unsigned DW    = 2 * FRAC
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          lin_i,
  input  logic signed [DW-1:0]          x_i,
  input  logic signed [DW-1:0]          y_i,
  input  logic signed [DW-1:0]          u_a_i,
  input  logic signed [DW-1:0]          u_b_i,
  input  logic signed [DW-1:0]          u_c_i,
  input  logic signed [DW-1:0]          w_a_i,
  input  logic signed [DW-1:0]          w_b_i,
  input  logic signed [DW-1:0]          w_c_i,
  output logic                          valid_o,
  output logic                          lin_o,
  output logic [LANES-1:0][DW-1:0]      pu_o,
  output logic [LANES-1:0][DW-1:0]      pw_o
);

  localparam logic signed [DW-1:0] ONE = DW'(1) << FRAC;

  function automatic logic signed [DW-1:0] qmul(input logic signed [DW-1:0] a,
                                                input logic signed [DW-1:0] b);
    logic signed [2*DW-1:0] p;
    p = (2*DW)'(a) * (2*DW)'(b);
    return DW'(p >>> FRAC);
  endfunction

  logic [LANES-1:0][DW-1:0] pu_d, pw_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [DW-1:0] xk, yk;
    assign xk = x_i + (((k % 2) != 0) ? ONE : '0);
    assign yk = y_i + (((k / 2) != 0) ? ONE : '0);
    assign pu_d[k] = qmul(u_a_i, xk) + qmul(u_b_i, yk) + u_c_i;
    assign pw_d[k] = qmul(w_a_i, xk) + qmul(w_b_i, yk) + w_c_i;
  end

  logic                     valid_q;
  logic                     lin_q;
  logic [LANES-1:0][DW-1:0] pu_q, pw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      lin_q <= lin_i;
      pu_q  <= pu_d;
      pw_q  <= pw_d;
    end
  end

  assign valid_o = valid_q;
  assign lin_o   = lin_q;
  assign pu_o    = pu_q;
  assign pw_o    = pw_q;

  // Quad lanes step by one pixel, so opposite edges of the quad differ equally.
  if (LANES >= 4) begin : g_quad_chk
    a_r2_quad_x_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> (DW'(pu_q[1] - pu_q[0]) == DW'(pu_q[3] - pu_q[2])));
    a_r2_quad_y_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> (DW'(pw_q[2] - pw_q[0]) == DW'(pw_q[3] - pw_q[1])));
  end

endmodule

// File: rtl/persp_interp_recip_stage.sv
module persp_interp_recip_stage #(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = 33
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] rem_i,
  input  logic [DW-1:0] div_i,
  input  logic [DW-1:0] quo_i,
  input  logic          sat_i,
  input  logic          neg_i,
  input  logic [PW-1:0] pay_i,
  output logic          valid_o,
  output logic [DW-1:0] rem_o,
  output logic [DW-1:0] div_o,
  output logic [DW-1:0] quo_o,
  output logic          sat_o,
  output logic          neg_o,
  output logic [PW-1:0] pay_o
);

  logic [DW:0] sh;
  logic        ge;

  always_comb begin
    sh = {rem_i, 1'b0};
    ge = (sh >= {1'b0, div_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      rem_o <= ge ? DW'(sh - {1'b0, div_i}) : DW'(sh);
      quo_o <= DW'({quo_i, ge});
      div_o <= div_i;
      sat_o <= sat_i;
      neg_o <= neg_i;
      pay_o <= pay_i;
    end
  end

endmodule

// File: rtl/persp_interp_recip.sv
module persp_interp_recip
  import persp_interp_pkg::*;
#(
  parameter  int unsigned FRAC = FRAC_W,
  parameter  int unsigned PW   = 2 * FRAC + 1,
  localparam int unsigned DW   = 2 * FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] den_i,
  input  logic [PW-1:0]        pay_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] w_o,
  output logic [PW-1:0]        pay_o
);

  localparam logic [DW-1:0]   MAXP    = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0]   SAT_LIM = DW'(2);
  localparam logic [2*DW:0]   DIVIDND = (2*DW+1)'(1) << DW;

  logic          v   [0:DW];
  logic [DW-1:0] rem [0:DW];
  logic [DW-1:0] dv  [0:DW];
  logic [DW-1:0] quo [0:DW];
  logic          sat [0:DW];
  logic          neg [0:DW];
  logic [PW-1:0] pay [0:DW];

  // Dividend 2^DW: its leading one seeds the remainder, zeros shift in after it.
  always_comb begin
    v[0]   = valid_i;
    neg[0] = den_i[DW-1];
    dv[0]  = neg[0] ? DW'(-den_i) : DW'(den_i);
    sat[0] = (dv[0] <= SAT_LIM);
    rem[0] = DW'(1);
    quo[0] = '0;
    pay[0] = pay_i;
  end

  for (genvar s = 0; s < DW; s++) begin : g_stage
    persp_interp_recip_stage #(.DW(DW), .PW(PW)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (v[s]),
      .rem_i   (rem[s]),
      .div_i   (dv[s]),
      .quo_i   (quo[s]),
      .sat_i   (sat[s]),
      .neg_i   (neg[s]),
      .pay_i   (pay[s]),
      .valid_o (v[s+1]),
      .rem_o   (rem[s+1]),
      .div_o   (dv[s+1]),
      .quo_o   (quo[s+1]),
      .sat_o   (sat[s+1]),
      .neg_o   (neg[s+1]),
      .pay_o   (pay[s+1])
    );
  end

  logic [DW-1:0] wmag;
  assign wmag    = sat[DW] ? MAXP : quo[DW];
  assign w_o     = neg[DW] ? -$signed(wmag) : $signed(wmag);
  assign valid_o = v[DW];
  assign pay_o   = pay[DW];

  logic [2*DW:0] chk_sum;
  always_comb chk_sum = (2*DW+1)'(quo[DW]) * (2*DW+1)'(dv[DW]) + (2*DW+1)'(rem[DW]);

  a_r3_recip_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v[DW] && !sat[DW]) |-> (chk_sum == DIVIDND) && (rem[DW] < dv[DW]));

  a_r4_sat_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v[DW] |-> (sat[DW] == (dv[DW] <= SAT_LIM)));

endmodule

// File: rtl/persp_interp.sv
module persp_interp
  import persp_interp_pkg::*;
#(
  parameter  int unsigned FRAC  = FRAC_W,
  parameter  int unsigned LANES = QUAD_LANES,
  localparam int unsigned DW    = 2 * FRAC
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  linear_i,
  input  logic [DW-1:0]         base_x_i,
  input  logic [DW-1:0]         base_y_i,
  input  logic [DW-1:0]         u_a_i,
  input  logic [DW-1:0]         u_b_i,
  input  logic [DW-1:0]         u_c_i,
  input  logic [DW-1:0]         w_a_i,
  input  logic [DW-1:0]         w_b_i,
  input  logic [DW-1:0]         w_c_i,
  output logic                  valid_o,
  output logic [LANES*DW-1:0]   attr_o
);

  localparam int unsigned LAT = DW + 2;
  localparam int unsigned CW  = $clog2(LAT + 2) + 1;

  function automatic logic signed [DW-1:0] qmul(input logic signed [DW-1:0] a,
                                                input logic signed [DW-1:0] b);
    logic signed [2*DW-1:0] p;
    p = (2*DW)'(a) * (2*DW)'(b);
    return DW'(p >>> FRAC);
  endfunction

  logic                     pl_valid, pl_lin;
  logic [LANES-1:0][DW-1:0] pl_pu, pl_pw;

  persp_interp_plane #(.FRAC(FRAC), .LANES(LANES)) u_plane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .lin_i   (linear_i),
    .x_i     (base_x_i),
    .y_i     (base_y_i),
    .u_a_i   (u_a_i),
    .u_b_i   (u_b_i),
    .u_c_i   (u_c_i),
    .w_a_i   (w_a_i),
    .w_b_i   (w_b_i),
    .w_c_i   (w_c_i),
    .valid_o (pl_valid),
    .lin_o   (pl_lin),
    .pu_o    (pl_pu),
    .pw_o    (pl_pw)
  );

  logic [LANES-1:0]         rc_valid;
  logic [LANES-1:0][DW-1:0] out_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [DW-1:0] w_k;
    logic [DW:0]          pay_k;
    interp_mode_e         mode_k;
    logic signed [DW-1:0] pu_k;

    persp_interp_recip #(.FRAC(FRAC), .PW(DW + 1)) u_recip (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (pl_valid),
      .den_i   ($signed(pl_pw[k])),
      .pay_i   ({pl_lin, pl_pu[k]}),
      .valid_o (rc_valid[k]),
      .w_o     (w_k),
      .pay_o   (pay_k)
    );

    assign mode_k   = interp_mode_e'(pay_k[DW]);
    assign pu_k     = $signed(pay_k[DW-1:0]);
    assign out_d[k] = (mode_k == MODE_LINEAR) ? pu_k : qmul(pu_k, w_k);
  end

  logic                     valid_q;
  logic [LANES-1:0][DW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= &rc_valid;
  end

  always_ff @(posedge clk_i) begin
    if (&rc_valid) out_q <= out_d;
  end

  assign valid_o = valid_q;
  assign attr_o  = out_q;

  // In-flight window check: groups accepted minus groups delivered.
  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CW'(valid_i) - CW'(valid_q);
  end

  a_r6_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(LAT));

  a_r7_no_spurious_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (inflight_q != '0));

endmodule

// File: tb/persp_interp_tb.sv
module persp_interp_tb;

  localparam int LAT_EDGES = 34;
  localparam int NEXP      = 4096;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0, linear_i = 1'b0;
  logic [31:0]   base_x_i = '0, base_y_i = '0;
  logic [31:0]   u_a_i = '0, u_b_i = '0, u_c_i = '0;
  logic [31:0]   w_a_i = '0, w_b_i = '0, w_c_i = '0;
  logic          valid_o;
  logic [127:0]  attr_o;

  always #2.5 clk = ~clk;

  persp_interp u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .linear_i(linear_i),
    .base_x_i(base_x_i), .base_y_i(base_y_i),
    .u_a_i(u_a_i), .u_b_i(u_b_i), .u_c_i(u_c_i),
    .w_a_i(w_a_i), .w_b_i(w_b_i), .w_c_i(w_c_i),
    .valid_o(valid_o), .attr_o(attr_o)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  int wr = 0, rd = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_v [0:NEXP-1][0:3];
  int          exp_c [0:NEXP-1];
  string       exp_t [0:NEXP-1];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] plane(int a, int b, int c, int x, int y);
    longint p;
    p = ((longint'(a) * longint'(x)) >>> 16) + ((longint'(b) * longint'(y)) >>> 16) + longint'(c);
    return p[31:0];
  endfunction

  function automatic longint recip(int pw);
    longint m, w;
    m = (pw < 0) ? -longint'(pw) : longint'(pw);
    if (m <= 2) w = 64'sh7FFF_FFFF;
    else        w = (64'sd1 <<< 32) / m;
    return (pw < 0) ? -w : w;
  endfunction

  task automatic grp(bit lin, int x, int y, int ua, int ub, int uc,
                     int wa, int wb, int wc, string tag);
    @(negedge clk);
    valid_i = 1'b1; linear_i = lin;
    base_x_i = x; base_y_i = y;
    u_a_i = ua; u_b_i = ub; u_c_i = uc;
    w_a_i = wa; w_b_i = wb; w_c_i = wc;
    for (int k = 0; k < 4; k++) begin
      int xk, yk, pu, pw;
      longint pr;
      xk = x + (((k % 2) != 0) ? 32'h0001_0000 : 0);
      yk = y + (((k / 2) != 0) ? 32'h0001_0000 : 0);
      pu = plane(ua, ub, uc, xk, yk);
      pw = plane(wa, wb, wc, xk, yk);
      if (lin) exp_v[wr][k] = pu;
      else begin
        pr = longint'(pu) * recip(pw);
        pr = pr >>> 16;
        exp_v[wr][k] = pr[31:0];
      end
    end
    exp_c[wr] = cyc;
    exp_t[wr] = tag;
    wr++;
  endtask

  task automatic idle(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; linear_i = i[0];
      base_x_i = seed * 7919 + i; u_c_i = 32'hDEAD_0000 ^ i; w_c_i = i;
    end
  endtask

  // Monitor: output due exactly LAT_EDGES after the drive cycle (R6), silent otherwise (R7).
  always @(negedge clk) begin
    if (mon_on) begin
      if (rd < wr && exp_c[rd] + LAT_EDGES == cyc) begin
        checks++;
        if (valid_o !== 1'b1) begin
          fails++;
          $display("FAIL R6 group %0d: valid_o=%b expected 1", rd, valid_o);
        end
        for (int k = 0; k < 4; k++) begin
          checks++;
          if (attr_o[32*k +: 32] !== exp_v[rd][k]) begin
            fails++;
            $display("FAIL %s group %0d lane %0d: got %h expected %h",
                     exp_t[rd], rd, k, attr_o[32*k +: 32], exp_v[rd][k]);
          end
        end
        rd++;
      end else begin
        checks++;
        if (valid_o !== 1'b0) begin
          fails++;
          $display("FAIL R7 cycle %0d: valid_o=%b expected 0", cyc, valid_o);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R7: reset state, with valid_i toggling while held in reset
    repeat (3) begin
      @(negedge clk);
      valid_i = ~valid_i;
      checks++;
      if (valid_o !== 1'b0) begin
        fails++;
        $display("FAIL R7 reset: valid_o=%b expected 0", valid_o);
      end
    end
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    mon_on = 1'b1;
    idle(4, 1);

    // R1 R2 R5 R8: linear sweep, W planes arbitrary (ignored), mode alternates with perspective
    for (int yi = -3; yi <= 3; yi++)
      for (int xi = -3; xi <= 3; xi++)
        for (int s = 0; s < 3; s++) begin
          int x, y;
          x = xi * 65536 + 32768;
          y = yi * 65536 + 32768;
          case (s)
            0: grp(1'b1, x, y, 32'h0003_4000, -32'h0001_2000, 32'h0010_0000,
                   0, 0, 0, "R5");
            1: grp(1'b1, x, y, -32'h0000_0123, 32'h0002_8001, -32'h0007_FFFF,
                   xi * 11, 32'h7FFF_0000, yi, "R1");
            default: grp(1'b0, x, y, 32'h0001_0000, 32'h0000_8000, 32'h0004_0000,
                         32'h0000_1000, 32'h0000_0800, 32'h0000_8000, "R8");
          endcase
        end

    // R3: perspective sweep, positive and negative 1/W planes
    for (int yi = -3; yi <= 3; yi++)
      for (int xi = -3; xi <= 3; xi++) begin
        int x, y;
        x = xi * 65536;
        y = yi * 65536 + 16384;
        grp(1'b0, x, y, 32'h0002_2000, -32'h0000_9000, 32'h0003_0000,
            32'h0000_2000, -32'h0000_1000, 32'h0000_C000, "R3");
        grp(1'b0, x, y, -32'h0000_7777, 32'h0001_1111, -32'h0002_0000,
            -32'h0000_0400, 32'h0000_0300, -32'h0001_8000, "R3");
      end

    idle(5, 2);

    // R4: W plane steps by one raw unit per lane; constant crosses zero
    for (int c = -5; c <= 4; c++) begin
      grp(1'b0, 0, 0, 32'h0000_0000, 32'h0000_0000, 32'h0001_8000,
          1, 0, c, "R4");
      grp(1'b0, 0, 0, 32'h0000_0000, 32'h0000_0000, -32'h0000_4000,
          0, 1, c, "R4");
    end
    grp(1'b0, 0, 0, 0, 0, 32'h0000_0100, 0, 0, 32'h8000_0000, "R4");
    grp(1'b0, 0, 0, 0, 0, 32'h0000_0100, 0, 0, 32'h7FFF_FFFF, "R4");

    // R6 R7: sparse groups separated by idle cycles carrying junk data
    for (int i = 0; i < 6; i++) begin
      grp(i[0], i * 65536, -i * 65536, 32'h0000_8000, 32'h0001_0000, i * 4096,
          32'h0000_0100, 32'h0000_0100, 32'h0002_0000, "R6");
      idle(i + 1, 10 + i);
    end

    idle(LAT_EDGES + 6, 3);
    checks++;
    if (rd != wr) begin
      fails++;
      $display("FAIL R6 delivery: got %0d groups expected %0d", rd, wr);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule